// File: doc/BRIEF.md
# Partitioned Cache Victim Selector

This block chooses which way of one set of a set-associative cache is replaced when a line is filled. The caller presents the state bits of every way in the addressed set (valid, dirty, locked, use), the identity of the requester that caused the fill, and the fill address. The block splits the address into a set index and a tag. It also reports whether any valid way already holds that tag. It then picks a victim way, or reports that no victim is available.

Each requester has its own eviction mask. Cores use identifiers 0 to NUM_CORES-1, and the shared hardware agents use identifier NUM_CORES. A 1 bit in a mask forbids that requester from evicting the way, and a 0 bit allows it. Locked ways are never replaced. Hit detection ignores both masks and locks.

Among the allowed, unlocked ways, an invalid way is taken first. Next comes a way whose use bit is clear. When every candidate has been used, the block takes the lowest candidate and asks the caller to clear the use bits of all candidates. A dirty victim raises a write-back flag. Masks are written and read back through a single-cycle configuration port. A mask that would forbid every way is rejected, and so is an identifier with no requester.

Top module: `cache_victim_sel`

## Requirements
- R1: The set index is req_addr[7+SET_BITS-1:7], because lines are 128 bytes. The tag is every address bit above the index.
- R2: After reset every mask reads 0, so all ways are allowed. When cfg_we is high with an accepted write, the mask of requester cfg_id is replaced at the clock edge. cfg_rd_mask shows the mask of requester cfg_rd_id with no delay.
- R3: A write whose mask has every bit set is rejected, and so is a write whose cfg_id is greater than NUM_CORES. cfg_err is high in that same cycle, and no mask changes.
- R4: hit is high when any valid way's tag equals the address tag. hit_way is the lowest such way. Masks and lock bits have no effect on hit detection.
- R5: Candidates are the ways whose mask bit for req_id is 0 and whose lock bit is 0. A victim is always a candidate. A req_id above NUM_CORES has no candidates.
- R6: If any candidate is invalid, the victim is the lowest-index invalid candidate.
- R7: Otherwise, if any candidate has its use bit at 0, the victim is the lowest such candidate and use_clear is 0.
- R8: If every candidate has its use bit set, the victim is the lowest candidate. use_clear equals the candidate set.
- R9: With no candidate, no_victim is 1, victim_valid is 0 and victim_way is 0. no_victim and victim_valid are never high together.
- R10: wb_needed is 1 exactly when a victim is reported and that way is both valid and dirty.
- R11: While req_valid is 0, victim_valid, no_victim, wb_needed and use_clear are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_id | input | ID_W | Requester whose mask is written |
| cfg_mask | input | NUM_WAYS | Mask value to write (1 = way forbidden) |
| cfg_err | output | 1 | Write rejected this cycle |
| cfg_rd_id | input | ID_W | Requester whose mask is read |
| cfg_rd_mask | output | NUM_WAYS | Mask of cfg_rd_id (all ones for an unknown id) |
| req_valid | input | 1 | Fill request present |
| req_id | input | ID_W | Requester of the fill |
| req_addr | input | ADDR_W | Physical address of the fill |
| way_valid | input | NUM_WAYS | Valid bit per way |
| way_dirty | input | NUM_WAYS | Dirty bit per way |
| way_lock | input | NUM_WAYS | Lock bit per way |
| way_use | input | NUM_WAYS | Use bit per way |
| way_tag | input | NUM_WAYS*TAG_W | Stored tag per way, way 0 in the low bits |
| set_index | output | SET_BITS | Set index of req_addr |
| addr_tag | output | TAG_W | Tag of req_addr |
| hit | output | 1 | A valid way holds addr_tag |
| hit_way | output | WAY_W | Lowest matching way |
| victim_valid | output | 1 | A victim was chosen |
| victim_way | output | WAY_W | Chosen way |
| no_victim | output | 1 | No allowed unlocked way exists |
| wb_needed | output | 1 | Victim is valid and dirty |
| use_clear | output | NUM_WAYS | Use bits to clear after an all-used pick |

## Verification
Every cycle, the assertions check that a victim is never locked or forbidden to its requester. They also check that an invalid-first pick lands on an invalid way, that a use-based pick lands on a clear use bit, and that use_clear only names used ways and includes the victim. They further cover that the write-back flag implies a valid dirty victim, that a rejected write leaves every mask unchanged, and that an idle request raises no fill output. Only the bench's scenarios show the orderings themselves: that the lowest index wins, that invalid ways beat unused ones, and that per-requester masks steer the choice differently for the same set. The same holds for the address split and for hits found in locked or forbidden ways.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

    localparam int LINE_OFS = 7;
    localparam int MAX_WAYS = 32;

    typedef enum logic [1:0] {
        PICK_NONE    = 2'd0,
        PICK_INVALID = 2'd1,
        PICK_UNUSED  = 2'd2,
        PICK_AGED    = 2'd3
    } pick_e;

    function automatic logic [4:0] cvs_first(input logic [MAX_WAYS-1:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = MAX_WAYS - 1; i >= 0; i--) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/cvs_addr_split.sv
module cvs_addr_split #(
    parameter int ADDR_W   = 40,
    parameter int SET_BITS = 8,
    localparam int TAG_W   = ADDR_W - cvs_pkg::LINE_OFS - SET_BITS
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [SET_BITS-1:0] set_index,
    output logic [TAG_W-1:0]    tag
);
    localparam int IDX_LO = cvs_pkg::LINE_OFS;
    localparam int TAG_LO = IDX_LO + SET_BITS;

    assign set_index = addr[TAG_LO-1:IDX_LO];
    assign tag       = addr[ADDR_W-1:TAG_LO];
endmodule

// File: rtl/cvs_mask_bank.sv
module cvs_mask_bank #(
    parameter int NUM_WAYS = 8,
    parameter int NUM_REQ  = 5,
    localparam int ID_W    = $clog2(NUM_REQ)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [ID_W-1:0]              wid,
    input  logic [NUM_WAYS-1:0]          wmask,
    output logic                         err,
    input  logic [ID_W-1:0]              rd_id,
    output logic [NUM_WAYS-1:0]          rd_mask,
    input  logic [ID_W-1:0]              sel_id,
    output logic [NUM_WAYS-1:0]          sel_mask,
    output logic [NUM_WAYS*NUM_REQ-1:0]  masks_flat
);
    logic [NUM_WAYS-1:0] mask_q [NUM_REQ];
    logic                id_bad;
    logic                reject;

    assign id_bad = {1'b0, wid} >= (ID_W+1)'(NUM_REQ);
    assign reject = (&wmask) | id_bad;
    assign err    = we & reject;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[r] <= '0;
            end else if (we && !reject && wid == ID_W'(r)) begin
                mask_q[r] <= wmask;
            end
        end
        assign masks_flat[r*NUM_WAYS +: NUM_WAYS] = mask_q[r];
    end

    always_comb begin
        rd_mask  = '1;
        sel_mask = '1;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (rd_id == ID_W'(r))  rd_mask  = mask_q[r];
            if (sel_id == ID_W'(r)) sel_mask = mask_q[r];
        end
    end
endmodule

// File: rtl/cvs_tag_match.sv
module cvs_tag_match #(
    parameter int NUM_WAYS = 8,
    parameter int TAG_W    = 25,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0]       way_valid,
    input  logic [NUM_WAYS*TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]          tag,
    output logic                      hit,
    output logic [WAY_W-1:0]          hit_way
);
    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w*TAG_W +: TAG_W] == tag);
    end

    assign hit     = |match;
    assign hit_way = WAY_W'(cvs_pkg::cvs_first(cvs_pkg::MAX_WAYS'(match)));
endmodule

// File: rtl/cvs_victim_pick.sv
module cvs_victim_pick #(
    parameter int NUM_WAYS = 8,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic                req_valid,
    input  logic [NUM_WAYS-1:0] forbid,
    input  logic [NUM_WAYS-1:0] way_valid,
    input  logic [NUM_WAYS-1:0] way_dirty,
    input  logic [NUM_WAYS-1:0] way_lock,
    input  logic [NUM_WAYS-1:0] way_use,
    output logic                victim_valid,
    output logic [WAY_W-1:0]    victim_way,
    output logic                no_victim,
    output logic                wb_needed,
    output logic [NUM_WAYS-1:0] use_clear,
    output cvs_pkg::pick_e      pick_kind
);
    import cvs_pkg::*;

    logic [NUM_WAYS-1:0] cand;
    logic [NUM_WAYS-1:0] cand_inv;
    logic [NUM_WAYS-1:0] cand_free;
    logic [NUM_WAYS-1:0] pool;

    assign cand      = ~forbid & ~way_lock;
    assign cand_inv  = cand & ~way_valid;
    assign cand_free = cand & ~way_use;

    always_comb begin
        pick_kind = PICK_NONE;
        pool      = '0;
        use_clear = '0;
        if (req_valid) begin
            if (|cand_inv) begin
                pick_kind = PICK_INVALID;
                pool      = cand_inv;
            end else if (|cand_free) begin
                pick_kind = PICK_UNUSED;
                pool      = cand_free;
            end else if (|cand) begin
                pick_kind = PICK_AGED;
                pool      = cand;
                use_clear = cand;
            end
        end
    end

    assign victim_valid = (pick_kind != PICK_NONE);
    assign no_victim    = req_valid && (cand == '0);
    assign victim_way   = WAY_W'(cvs_first(MAX_WAYS'(pool)));
    assign wb_needed    = victim_valid && way_valid[victim_way] && way_dirty[victim_way];
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
    parameter int NUM_WAYS  = 8,
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 40,
    parameter int SET_BITS  = 8,
    localparam int NUM_REQ  = NUM_CORES + 1,
    localparam int ID_W     = $clog2(NUM_REQ),
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int TAG_W    = ADDR_W - cvs_pkg::LINE_OFS - SET_BITS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [ID_W-1:0]           cfg_id,
    input  logic [NUM_WAYS-1:0]       cfg_mask,
    output logic                      cfg_err,
    input  logic [ID_W-1:0]           cfg_rd_id,
    output logic [NUM_WAYS-1:0]       cfg_rd_mask,
    input  logic                      req_valid,
    input  logic [ID_W-1:0]           req_id,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [NUM_WAYS-1:0]       way_valid,
    input  logic [NUM_WAYS-1:0]       way_dirty,
    input  logic [NUM_WAYS-1:0]       way_lock,
    input  logic [NUM_WAYS-1:0]       way_use,
    input  logic [NUM_WAYS*TAG_W-1:0] way_tag,
    output logic [SET_BITS-1:0]       set_index,
    output logic [TAG_W-1:0]          addr_tag,
    output logic                      hit,
    output logic [WAY_W-1:0]          hit_way,
    output logic                      victim_valid,
    output logic [WAY_W-1:0]          victim_way,
    output logic                      no_victim,
    output logic                      wb_needed,
    output logic [NUM_WAYS-1:0]       use_clear
);
    logic [NUM_WAYS-1:0]         sel_mask;
    logic [NUM_WAYS*NUM_REQ-1:0] masks_flat;
    cvs_pkg::pick_e              pick_kind;

    cvs_addr_split #(.ADDR_W(ADDR_W), .SET_BITS(SET_BITS)) u_split (
        .addr      (req_addr),
        .set_index (set_index),
        .tag       (addr_tag)
    );

    cvs_mask_bank #(.NUM_WAYS(NUM_WAYS), .NUM_REQ(NUM_REQ)) u_masks (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .wid        (cfg_id),
        .wmask      (cfg_mask),
        .err        (cfg_err),
        .rd_id      (cfg_rd_id),
        .rd_mask    (cfg_rd_mask),
        .sel_id     (req_id),
        .sel_mask   (sel_mask),
        .masks_flat (masks_flat)
    );

    cvs_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match (
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .tag       (addr_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    cvs_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .req_valid    (req_valid),
        .forbid       (sel_mask),
        .way_valid    (way_valid),
        .way_dirty    (way_dirty),
        .way_lock     (way_lock),
        .way_use      (way_use),
        .victim_valid (victim_valid),
        .victim_way   (victim_way),
        .no_victim    (no_victim),
        .wb_needed    (wb_needed),
        .use_clear    (use_clear),
        .pick_kind    (pick_kind)
    );
endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
    parameter int NUM_WAYS  = 8,
    parameter int MASK_BITS = 40,
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_err,
    input logic [MASK_BITS-1:0] masks_flat,
    input logic                 req_valid,
    input logic                 victim_valid,
    input logic [WAY_W-1:0]     victim_way,
    input logic                 no_victim,
    input logic                 wb_needed,
    input logic [NUM_WAYS-1:0]  use_clear,
    input logic [NUM_WAYS-1:0]  sel_mask,
    input logic [NUM_WAYS-1:0]  way_valid,
    input logic [NUM_WAYS-1:0]  way_dirty,
    input logic [NUM_WAYS-1:0]  way_lock,
    input logic [NUM_WAYS-1:0]  way_use,
    input cvs_pkg::pick_e       pick_kind
);
    import cvs_pkg::*;

    p_reject_hold_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> $stable(masks_flat));

    p_victim_allowed_r5: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> (!way_lock[victim_way] && !sel_mask[victim_way]));

    p_invalid_first_r6: assert property (@(posedge clk) disable iff (rst)
        (pick_kind == PICK_INVALID) |-> !way_valid[victim_way]);

    p_unused_pick_r7: assert property (@(posedge clk) disable iff (rst)
        (pick_kind == PICK_UNUSED) |-> (!way_use[victim_way] && use_clear == '0));

    p_aged_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (use_clear != '0) |-> (victim_valid && (use_clear & ~way_use) == '0
                               && use_clear[victim_way]));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(victim_valid && no_victim));

    p_writeback_r10: assert property (@(posedge clk) disable iff (rst)
        wb_needed |-> (victim_valid && way_valid[victim_way] && way_dirty[victim_way]));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!victim_valid && !no_victim && !wb_needed && use_clear == '0));
endmodule

bind cache_victim_sel cvs_checker #(
    .NUM_WAYS  (NUM_WAYS),
    .MASK_BITS (NUM_WAYS*NUM_REQ)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_err      (cfg_err),
    .masks_flat   (masks_flat),
    .req_valid    (req_valid),
    .victim_valid (victim_valid),
    .victim_way   (victim_way),
    .no_victim    (no_victim),
    .wb_needed    (wb_needed),
    .use_clear    (use_clear),
    .sel_mask     (sel_mask),
    .way_valid    (way_valid),
    .way_dirty    (way_dirty),
    .way_lock     (way_lock),
    .way_use      (way_use),
    .pick_kind    (pick_kind)
);

// File: tb/cache_victim_sel_tb.sv
`timescale 1ns/1ps
module cache_victim_sel_tb;
    localparam int NW = 8;
    localparam int TW = 25;

    logic          clk = 0;
    logic          rst = 1;
    logic          cfg_we = 0;
    logic [2:0]    cfg_id = 0;
    logic [NW-1:0] cfg_mask = 0;
    logic          cfg_err;
    logic [2:0]    cfg_rd_id = 0;
    logic [NW-1:0] cfg_rd_mask;
    logic          req_valid = 0;
    logic [2:0]    req_id = 0;
    logic [39:0]   req_addr = 0;
    logic [NW-1:0] way_valid = 0, way_dirty = 0, way_lock = 0, way_use = 0;
    logic [NW*TW-1:0] way_tag = 0;
    logic [7:0]    set_index;
    logic [TW-1:0] addr_tag;
    logic          hit;
    logic [2:0]    hit_way;
    logic          victim_valid;
    logic [2:0]    victim_way;
    logic          no_victim;
    logic          wb_needed;
    logic [NW-1:0] use_clear;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cache_victim_sel u_dut (.*);

    typedef struct packed {
        logic [2:0] id;
        logic [7:0] v, d, l, u;
        logic       ev;
        logic [2:0] way;
        logic       nv;
        logic       wb;
        logic [7:0] clr;
    } vec_t;

    // masks during the table: id0 = 00, id1 = F0, id2 = 00, id3 = 00, id4 = 0F
    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{3'd0, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00}, // R7
        '{3'd0, 8'hFB, 8'h00, 8'h00, 8'h00, 1'b1, 3'd2, 1'b0, 1'b0, 8'h00}, // R6
        '{3'd0, 8'hFF, 8'h00, 8'h01, 8'h0F, 1'b1, 3'd4, 1'b0, 1'b0, 8'h00}, // R7 R5
        '{3'd0, 8'hFF, 8'h00, 8'h03, 8'hFF, 1'b1, 3'd2, 1'b0, 1'b0, 8'hFC}, // R8
        '{3'd1, 8'hFF, 8'h01, 8'h00, 8'h00, 1'b1, 3'd0, 1'b0, 1'b1, 8'h00}, // R10
        '{3'd1, 8'h7F, 8'h00, 8'h00, 8'h00, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00}, // R5
        '{3'd1, 8'hFF, 8'h00, 8'h0F, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 8'h00}, // R9
        '{3'd4, 8'hFF, 8'hF0, 8'h00, 8'h10, 1'b1, 3'd5, 1'b0, 1'b1, 8'h00}, // R5 R10
        '{3'd4, 8'hFF, 8'h00, 8'h80, 8'hF0, 1'b1, 3'd4, 1'b0, 1'b0, 8'h70}, // R8
        '{3'd2, 8'hEF, 8'hFF, 8'h10, 8'h00, 1'b1, 3'd0, 1'b0, 1'b1, 8'h00}, // R5 R10
        '{3'd3, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00}, // R6 R10
        '{3'd5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 8'h00}  // R5 R9
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] id, input logic [7:0] m, input logic exp_err);
        @(negedge clk);
        cfg_we = 1; cfg_id = id; cfg_mask = m;
        #5 check("R3 cfg_err", 64'(cfg_err), 64'(exp_err));
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R2 reset state
        for (int i = 0; i < 5; i++) begin
            cfg_rd_id = 3'(i);
            #1 check("R2 reset mask", 64'(cfg_rd_mask), 64'h0);
        end
        // R11 idle request
        way_valid = 8'hFF; way_dirty = 8'hFF; way_use = 8'hFF;
        #1 check("R11 idle", {victim_valid, no_victim, wb_needed, use_clear}, 64'h0);

        // R2 writes
        cfg_write(3'd1, 8'hF0, 1'b0);
        cfg_write(3'd4, 8'h0F, 1'b0);
        cfg_rd_id = 3'd1; #1 check("R2 mask id1", 64'(cfg_rd_mask), 64'hF0);
        cfg_rd_id = 3'd4; #1 check("R2 mask id4", 64'(cfg_rd_mask), 64'h0F);
        // R3 rejections
        cfg_write(3'd1, 8'hFF, 1'b1);
        cfg_rd_id = 3'd1; #1 check("R3 all-ones kept", 64'(cfg_rd_mask), 64'hF0);
        cfg_write(3'd6, 8'h01, 1'b1);
        for (int i = 0; i < 5; i++) begin
            cfg_rd_id = 3'(i);
            #1 check("R3 bad id no change", 64'(cfg_rd_mask),
                     (i == 1) ? 64'hF0 : (i == 4) ? 64'h0F : 64'h0);
        end

        // table walk
        @(negedge clk);
        req_valid = 1;
        for (int k = 0; k < NV; k++) begin
            req_id = VT[k].id; way_valid = VT[k].v; way_dirty = VT[k].d;
            way_lock = VT[k].l; way_use = VT[k].u;
            #5;
            check($sformatf("R5-R10 vec%0d victim_valid", k), 64'(victim_valid), 64'(VT[k].ev));
            check($sformatf("R6 R7 R8 vec%0d way", k), 64'(victim_way), 64'(VT[k].way));
            check($sformatf("R9 vec%0d no_victim", k), 64'(no_victim), 64'(VT[k].nv));
            check($sformatf("R10 vec%0d wb", k), 64'(wb_needed), 64'(VT[k].wb));
            check($sformatf("R8 vec%0d use_clear", k), 64'(use_clear), 64'(VT[k].clr));
            @(negedge clk);
        end

        // R1 address split
        req_addr = {25'h1ABCDE, 8'h5A, 7'h33};
        #1 check("R1 set_index", 64'(set_index), 64'h5A);
        check("R1 tag", 64'(addr_tag), 64'h1ABCDE);

        // R4 hit in locked, forbidden ways
        for (int w = 0; w < NW; w++) way_tag[w*TW +: TW] = 25'(100 + w);
        way_tag[5*TW +: TW] = 25'd103;
        req_id = 3'd1; way_valid = 8'hFF; way_lock = 8'hFF;
        req_addr = {25'd103, 8'h01, 7'h00};
        #1 check("R4 hit", 64'(hit), 64'h1);
        check("R4 hit_way lowest", 64'(hit_way), 64'h3);
        way_valid = 8'hF7;
        #1 check("R4 hit_way skips invalid", 64'(hit_way), 64'h5);
        req_addr = {25'd99, 8'h01, 7'h00};
        #1 check("R4 miss", 64'(hit), 64'h0);

        // R11 again after use
        req_valid = 0; way_lock = 0; way_use = 8'hFF;
        #1 check("R11 idle end", {victim_valid, no_victim, wb_needed, use_clear}, 64'h0);

        // R2 reset clears masks
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        cfg_rd_id = 3'd1; #1 check("R2 mask after reset", 64'(cfg_rd_mask), 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule